// File: doc/BRIEF.md
# Adaptive LMS FIR Noise Filter (Serial Output, Parallel Adaptation)

This block cleans a noisy phase-difference stream with a 64-tap FIR filter whose coefficients adapt by the least-mean-square rule. An upstream stage presents one input sample together with the matching desired sample on a valid/ready handshake. The block then works out the filter output one tap per clock on a single multiply-accumulate path. Next it forms the error between the desired sample and the output. Finally it corrects all coefficients in a single clock, moves the new sample into its history and raises a one-cycle done strobe alongside the output and the error.

All arithmetic is signed two's-complement fixed point. The history and the coefficients are plain integers. The coefficients carry FRAC fractional bits, so the output is the accumulated sum shifted right by FRAC. The adaptation step size is a power of two, selected by a right-shift amount on an input port. A synchronous clear empties the history and zeroes the coefficients and outputs without a reset.

Top module: `lms_fir`

## Requirements
- R1: After reset, in_ready is 1, done is 0 and y_out and e_out are 0. The history and all coefficients are zero, so the first sample yields y_out = 0 and e_out = d_in.
- R2: A sample is taken only on a clock edge where in_valid and in_ready are both 1. in_ready is 0 from the cycle after acceptance until done is raised, and in_valid is ignored during that time.
- R3: done is high for exactly one cycle, on the NTAPS+2'th rising edge after the accepting edge (66 edges for 64 taps). in_ready is 1 again in that same cycle.
- R4: y_out = sat16((sum over j=1..64 of w_j * x(k-j)) >>> FRAC), with FRAC = 14. The current sample x(k) does not enter its own output.
- R5: The running sum saturates to the signed ACCW-bit range (ACCW = 36) after every tap is added, and y_out saturates to the signed 16-bit range.
- R6: e_out = sat16(d(k) - y(k)), where d(k) is the desired sample taken with x(k).
- R7: All coefficients update in the same cycle as w_j = sat18(w_j + ((e(k) * x(k-j)) >>> mu_shift)). The shift is arithmetic (floor), the product is 32 bits, and mu_shift is held during the sequence.
- R8: After the update, x(k) becomes x(k-1) for the next sample and the oldest sample drops out.
- R9: When clr is 1 on a clock edge, the history, coefficients, y_out and e_out go to zero and any sequence in progress is abandoned, so in_ready is 1 afterwards. clr wins over a simultaneous acceptance.
- R10: y_out and e_out change only in a cycle where done is 1, or in the cycle after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of history, coefficients and outputs |
| mu_shift | input | 5 | Step size as a right-shift amount |
| in_valid | input | 1 | Input and desired samples are valid |
| x_in | input | 16 | Input sample x(k), signed |
| d_in | input | 16 | Desired sample d(k), signed |
| in_ready | output | 1 | Block is idle and accepts a sample |
| y_out | output | 16 | Filter output y(k), signed |
| e_out | output | 16 | Error e(k), signed |
| done | output | 1 | One-cycle strobe: y_out and e_out are new |

## Verification
The checker watches the handshake and the sequencing on every cycle. It confirms that acceptance makes the block busy and that done arrives after exactly NTAPS+2 busy edges, for one cycle only, with the block ready again. It also confirms that a clear returns the block to idle with zeroed outputs and that the outputs hold still between done strobes. The numeric content can only be shown by the bench's scenarios, which compare every output and error against a reference model of the filter. That content covers the delayed-tap sum, the saturating accumulation, the error, the parallel coefficient update with its shift, and the history advance. The model is driven with random samples and step sizes, a coefficient-saturating training run, clears in mid-sequence and a clear that collides with acceptance.

// File: rtl/lms_fir_pkg.sv
package lms_fir_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MAC  = 2'd1,
        PH_ERR  = 2'd2,
        PH_UPD  = 2'd3
    } lms_phase_e;
endpackage

// File: rtl/lms_tap_line.sv
module lms_tap_line #(
    parameter int NTAPS = 64,
    parameter int DW    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        shift_en,
    input  logic [DW-1:0]               x_new,
    output logic [NTAPS-1:0][DW-1:0]    taps
);
    // taps[0] holds x(k-1), taps[NTAPS-1] holds x(k-NTAPS)
    typedef struct packed {
        logic [NTAPS-1:0][DW-1:0] line;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (shift_en) begin
            line_d.line[0] = x_new;
            for (int j = 1; j < NTAPS; j++) begin
                line_d.line[j] = line_q.line[j-1];
            end
        end
        if (clr) begin
            line_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign taps = line_q.line;
endmodule

// File: rtl/lms_coef_bank.sv
module lms_coef_bank #(
    parameter int NTAPS = 64,
    parameter int DW    = 16,
    parameter int WW    = 18,
    parameter int MUW   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        upd_en,
    input  logic [DW-1:0]               err,
    input  logic [MUW-1:0]              mu_shift,
    input  logic [NTAPS-1:0][DW-1:0]    taps,
    output logic [NTAPS-1:0][WW-1:0]    weights
);
    localparam int PW = 2 * DW;
    localparam int SW = ((PW > WW) ? PW : WW) + 1;
    localparam logic signed [SW-1:0] W_MAX = signed'({{(SW-WW+1){1'b0}}, {(WW-1){1'b1}}});
    localparam logic signed [SW-1:0] W_MIN = signed'({{(SW-WW+1){1'b1}}, {(WW-1){1'b0}}});

    typedef struct packed {
        logic [NTAPS-1:0][WW-1:0] w;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NTAPS-1:0][WW-1:0] w_new;

    // one step-and-saturate lane per tap, all evaluated in the same cycle
    for (genvar j = 0; j < NTAPS; j++) begin : g_lane
        logic signed [PW-1:0] grad;
        logic signed [PW-1:0] step;
        logic signed [SW-1:0] sum;

        always_comb begin
            grad = $signed(err) * $signed(taps[j]);
            step = grad >>> mu_shift;
            sum  = SW'($signed(weights[j])) + SW'(step);
            if (sum > W_MAX) begin
                w_new[j] = W_MAX[WW-1:0];
            end else if (sum < W_MIN) begin
                w_new[j] = W_MIN[WW-1:0];
            end else begin
                w_new[j] = sum[WW-1:0];
            end
        end
    end

    always_comb begin
        bank_d = bank_q;
        if (upd_en) begin
            bank_d.w = w_new;
        end
        if (clr) begin
            bank_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign weights = bank_q.w;
endmodule

// File: rtl/lms_seq_mac.sv
module lms_seq_mac
    import lms_fir_pkg::*;
#(
    parameter int NTAPS = 64,
    parameter int DW    = 16,
    parameter int WW    = 18,
    parameter int ACCW  = 36,
    parameter int FRAC  = 14,
    parameter int IW    = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            in_valid,
    input  logic [DW-1:0]   x_in,
    input  logic [DW-1:0]   d_in,
    input  logic [DW-1:0]   tap_x,
    input  logic [WW-1:0]   tap_w,
    output logic            in_ready,
    output logic [IW-1:0]   idx,
    output logic [DW-1:0]   x_hold,
    output logic            upd_en,
    output logic [DW-1:0]   err_val,
    output logic [DW-1:0]   y_out,
    output logic [DW-1:0]   e_out,
    output logic            done
);
    localparam int PRW = DW + WW;
    localparam logic signed [ACCW:0]   ACC_MAX = signed'({2'b00, {(ACCW-1){1'b1}}});
    localparam logic signed [ACCW:0]   ACC_MIN = signed'({2'b11, {(ACCW-1){1'b0}}});
    localparam logic signed [ACCW-1:0] Y_MAX   = signed'({{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}});
    localparam logic signed [ACCW-1:0] Y_MIN   = signed'({{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}});
    localparam logic signed [DW:0]     E_MAX   = signed'({2'b00, {(DW-1){1'b1}}});
    localparam logic signed [DW:0]     E_MIN   = signed'({2'b11, {(DW-1){1'b0}}});
    localparam logic [IW-1:0]          LAST    = IW'(NTAPS - 1);

    typedef struct packed {
        lms_phase_e             phase;
        logic [IW-1:0]          idx;
        logic signed [ACCW-1:0] acc;
        logic [DW-1:0]          x_hold;
        logic [DW-1:0]          d_hold;
        logic [DW-1:0]          y_int;
        logic [DW-1:0]          e_int;
        logic [DW-1:0]          y_o;
        logic [DW-1:0]          e_o;
        logic                   done;
    } seq_t;

    seq_t s_d, s_q;

    logic signed [PRW-1:0]  prod;
    logic signed [ACCW:0]   acc_sum;
    logic signed [ACCW-1:0] acc_next;
    logic signed [ACCW-1:0] acc_shr;
    logic [DW-1:0]          y_sat;
    logic signed [DW:0]     e_diff;
    logic [DW-1:0]          e_sat;

    // saturating multiply-accumulate for one tap
    always_comb begin
        prod    = $signed(tap_x) * $signed(tap_w);
        acc_sum = (ACCW+1)'(s_q.acc) + (ACCW+1)'(prod);
        if (acc_sum > ACC_MAX) begin
            acc_next = ACC_MAX[ACCW-1:0];
        end else if (acc_sum < ACC_MIN) begin
            acc_next = ACC_MIN[ACCW-1:0];
        end else begin
            acc_next = acc_sum[ACCW-1:0];
        end
    end

    // output scaling and error
    always_comb begin
        acc_shr = s_q.acc >>> FRAC;
        if (acc_shr > Y_MAX) begin
            y_sat = Y_MAX[DW-1:0];
        end else if (acc_shr < Y_MIN) begin
            y_sat = Y_MIN[DW-1:0];
        end else begin
            y_sat = acc_shr[DW-1:0];
        end
        e_diff = (DW+1)'($signed(s_q.d_hold)) - (DW+1)'($signed(y_sat));
        if (e_diff > E_MAX) begin
            e_sat = E_MAX[DW-1:0];
        end else if (e_diff < E_MIN) begin
            e_sat = E_MIN[DW-1:0];
        end else begin
            e_sat = e_diff[DW-1:0];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    s_d.phase  = PH_MAC;
                    s_d.idx    = '0;
                    s_d.acc    = '0;
                    s_d.x_hold = x_in;
                    s_d.d_hold = d_in;
                end
            end
            PH_MAC: begin
                s_d.acc = acc_next;
                if (s_q.idx == LAST) begin
                    s_d.phase = PH_ERR;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            PH_ERR: begin
                s_d.y_int = y_sat;
                s_d.e_int = e_sat;
                s_d.phase = PH_UPD;
            end
            PH_UPD: begin
                s_d.y_o   = s_q.y_int;
                s_d.e_o   = s_q.e_int;
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
        if (clr) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = (s_q.phase == PH_IDLE);
    assign upd_en   = (s_q.phase == PH_UPD);
    assign idx      = s_q.idx;
    assign x_hold   = s_q.x_hold;
    assign err_val  = s_q.e_int;
    assign y_out    = s_q.y_o;
    assign e_out    = s_q.e_o;
    assign done     = s_q.done;
endmodule

// File: rtl/lms_fir.sv
module lms_fir #(
    parameter int NTAPS = 64,
    parameter int DW    = 16,
    parameter int WW    = 18,
    parameter int FRAC  = 14,
    parameter int ACCW  = DW + WW + 2,
    parameter int MUW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [MUW-1:0]  mu_shift,
    input  logic            in_valid,
    input  logic [DW-1:0]   x_in,
    input  logic [DW-1:0]   d_in,
    output logic            in_ready,
    output logic [DW-1:0]   y_out,
    output logic [DW-1:0]   e_out,
    output logic            done
);
    localparam int IW = (NTAPS > 1) ? $clog2(NTAPS) : 1;

    logic [NTAPS-1:0][DW-1:0] taps;
    logic [NTAPS-1:0][WW-1:0] weights;
    logic [IW-1:0]            idx;
    logic [DW-1:0]            x_hold;
    logic [DW-1:0]            err_val;
    logic                     upd_en;
    logic [DW-1:0]            tap_x;
    logic [WW-1:0]            tap_w;

    // the single MAC reads one history/coefficient pair per cycle
    assign tap_x = taps[idx];
    assign tap_w = weights[idx];

    lms_seq_mac #(
        .NTAPS(NTAPS), .DW(DW), .WW(WW), .ACCW(ACCW), .FRAC(FRAC), .IW(IW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .x_in     (x_in),
        .d_in     (d_in),
        .tap_x    (tap_x),
        .tap_w    (tap_w),
        .in_ready (in_ready),
        .idx      (idx),
        .x_hold   (x_hold),
        .upd_en   (upd_en),
        .err_val  (err_val),
        .y_out    (y_out),
        .e_out    (e_out),
        .done     (done)
    );

    lms_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (upd_en),
        .x_new    (x_hold),
        .taps     (taps)
    );

    lms_coef_bank #(.NTAPS(NTAPS), .DW(DW), .WW(WW), .MUW(MUW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .upd_en   (upd_en),
        .err      (err_val),
        .mu_shift (mu_shift),
        .taps     (taps),
        .weights  (weights)
    );
endmodule

// File: rtl/lms_fir_chk.sv
module lms_fir_chk #(
    parameter int NTAPS = 64,
    parameter int DW    = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          in_valid,
    input logic          in_ready,
    input logic [DW-1:0] y_out,
    input logic [DW-1:0] e_out,
    input logic          done
);
    logic [15:0] busy_cnt;

    // edges seen since the last acceptance while the block was busy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (clr || (in_valid && in_ready)) begin
            busy_cnt <= '0;
        end else if (!in_ready && busy_cnt != 16'hFFFF) begin
            busy_cnt <= busy_cnt + 16'd1;
        end
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !clr) |=> !in_ready);

    a_r3_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == 16'(NTAPS + 2)));

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);

    a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (in_ready && !done && y_out == '0 && e_out == '0));

    a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(clr)) |-> ($stable(y_out) && $stable(e_out)));
endmodule

bind lms_fir lms_fir_chk #(.NTAPS(NTAPS), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .y_out    (y_out),
    .e_out    (e_out),
    .done     (done)
);

// File: tb/lms_fir_test.sv
`timescale 1ns/1ps
module lms_fir_test;
    localparam int NTAPS = 64;
    localparam int DW    = 16;
    localparam int WW    = 18;
    localparam int FRAC  = 14;
    localparam int ACCW  = DW + WW + 2;
    localparam int MUW   = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clr = 1'b0;
    logic [MUW-1:0] mu_shift = '0;
    logic           in_valid = 1'b0;
    logic [DW-1:0]  x_in = '0;
    logic [DW-1:0]  d_in = '0;
    logic           in_ready;
    logic [DW-1:0]  y_out;
    logic [DW-1:0]  e_out;
    logic           done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    longint wm [NTAPS];
    longint xm [NTAPS];

    always #10 clk = ~clk;

    lms_fir #(.NTAPS(NTAPS), .DW(DW), .WW(WW), .FRAC(FRAC), .ACCW(ACCW), .MUW(MUW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mu_shift(mu_shift),
        .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
        .in_ready(in_ready), .y_out(y_out), .e_out(e_out), .done(done)
    );

    function automatic longint sat(longint v, int bits);
        longint mx = (longint'(1) <<< (bits - 1)) - 1;
        longint mn = -(longint'(1) <<< (bits - 1));
        if (v > mx) return mx;
        if (v < mn) return mn;
        return v;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int j = 0; j < NTAPS; j++) begin
            wm[j] = 0;
            xm[j] = 0;
        end
    endtask

    // reference: delayed-tap sum, error, parallel update, history advance
    task automatic model_step(longint x, longint d, int mu, output longint ey, output longint ee);
        longint acc = 0;
        for (int j = 0; j < NTAPS; j++) acc = sat(acc + xm[j] * wm[j], ACCW);
        ey = sat(acc >>> FRAC, DW);
        ee = sat(d - ey, DW);
        for (int j = 0; j < NTAPS; j++) wm[j] = sat(wm[j] + ((ee * xm[j]) >>> mu), WW);
        for (int j = NTAPS - 1; j > 0; j--) xm[j] = xm[j-1];
        xm[0] = x;
    endtask

    task automatic run_sample(longint x, longint d, int mu, int noise_cycles);
        longint ey, ee;
        int n;
        model_step(x, d, mu, ey, ee);
        mu_shift = MUW'(mu);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        x_in = DW'(x);
        d_in = DW'(d);
        @(posedge clk);
        n = 0;
        @(negedge clk);
        in_valid = 1'b0;
        // R2: offers made while busy must be ignored
        for (int c = 0; c < noise_cycles; c++) begin
            in_valid = 1'b1;
            x_in = DW'($urandom);
            d_in = DW'($urandom);
            check("R2 busy in_ready", longint'(in_ready), 0);
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (!done && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        check("R3 done latency", n, NTAPS + 2);
        check("R3 ready with done", longint'(in_ready), 1);
        check("R4 y_out", longint'($signed(y_out)), ey);
        check("R6 e_out", longint'($signed(e_out)), ee);
        @(negedge clk);
        check("R3 done one cycle", longint'(done), 0);
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        check("R9 clear ready", longint'(in_ready), 1);
        check("R9 clear y_out", longint'(y_out), 0);
        check("R9 clear e_out", longint'(e_out), 0);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        longint ey, ee;
        void'($urandom(32'd4242));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset in_ready", longint'(in_ready), 1);
        check("R1 reset done", longint'(done), 0);
        check("R1 reset y_out", longint'(y_out), 0);
        check("R1 reset e_out", longint'(e_out), 0);

        // R1: zero coefficients give y = 0, e = d
        run_sample(1000, 5000, 4, 5);
        check("R1 first y zero", longint'($signed(y_out)), 0);
        check("R1 first e equals d", longint'($signed(e_out)), 5000);

        // R8: delayed input feeds the next output
        run_sample(-2000, 3000, 3, 0);

        // R4 R6 R7 R8: random stream, varied step size
        for (int i = 0; i < 40; i++) begin
            longint x = longint'($urandom % 16001) - 8000;
            longint d = longint'($urandom % 16001) - 8000;
            int mu = 6 + int'($urandom % 6);
            run_sample(x, d, mu, int'($urandom % 20));
        end

        // R9: clear in mid-sequence abandons the sample
        mu_shift = 5'd4;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; x_in = 16'd1234; d_in = 16'd999;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        pulse_clear();
        run_sample(700, -900, 5, 0);
        check("R9 after clear y zero", longint'($signed(y_out)), 0);

        // R9: clear beats a simultaneous acceptance
        pulse_clear();
        in_valid = 1'b1; x_in = 16'd3000; d_in = 16'd3000; clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0;
        check("R9 clr over accept ready", longint'(in_ready), 1);
        run_sample(500, 100, 6, 0);
        check("R9 clr over accept y zero", longint'($signed(y_out)), 0);

        // R5 R7: drive coefficients and the sum into saturation
        pulse_clear();
        for (int i = 0; i < 70; i++) run_sample(32767, 32767, 0, 0);
        check("R5 saturated y_out", longint'($signed(y_out)), 32767);
        for (int i = 0; i < 6; i++) run_sample(-32768, -32768, 0, 0);
        for (int i = 0; i < 10; i++) begin
            longint x = longint'($urandom % 65536) - 32768;
            run_sample(x, -x, int'($urandom % 4), 0);
        end

        // R7: large shift makes a tiny step after another clear
        pulse_clear();
        for (int i = 0; i < 8; i++) run_sample(longint'(i) * 1500 - 6000, 4000, 31, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule